// File: doc/BRIEF.md
# Stereo Serial Audio Port (I2S framing, slave)

This block is a slave serial audio port for a converter. It has three receive lanes and one transmit lane. The bit clock and the two word-select clocks come from an external master. The block samples them, together with the serial data, using a fast system clock through two-flop synchronizers. Edges of the bit clock are found inside the system-clock domain.

All three receive lanes share one bit clock and one receive word-select. Each lane turns its serial stream into a left and a right sample of the selected length. When a right word completes, the block raises a single-cycle strobe that presents the left and right words of every lane together. A word-select transition that cuts a word short throws away the partial word and raises a framing-error pulse.

The transmit side follows its own word-select. It takes a stereo pair from its parallel inputs once per frame and shifts it out MSB first. Each bit is launched on a falling bit-clock edge, so the receiver can capture it on the following rising edge.

Top module: `i2s_audio_port`

## Requirements
- R1: After reset, `rx_left`, `rx_right`, `rx_valid`, `rx_frame_err` and `tx_sd` are all zero. `tx_sd` stays low through the first transmit half-frame, because the transmit word holders reset to zero.
- R2: On each receive lane, the MSB of a word is the bit sampled on the second rising bit-clock edge after a `rx_ws` transition. The next n-1 rising edges supply the remaining bits, MSB first. The word is presented right-justified in a 32-bit field, and the bits above n are zero.
- R3: A word received while the word-select is low is a left sample. A word received while it is high is a right sample. The same rule holds for transmit.
- R4: `wl_sel` sets the word length n: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32 bits. Bits that follow the n-th bit inside a receive half-frame are ignored. `wl_sel` is only changed while reset is held.
- R5: All three lanes are framed by the same `sck` and `rx_ws`. Each lane captures its own `rx_sd` bit, and lane k occupies bits [32k+31:32k] of the flat outputs.
- R6: `rx_valid` pulses for exactly one system cycle each time a right word completes. It presents that right word together with the left word from the most recent completed left half-frame.
- R7: If `rx_ws` changes before n bits of the current half-frame have been captured, the partial word is dropped and the stored words keep their values. In that case no `rx_valid` follows, and `rx_frame_err` pulses for one cycle. The half-frame that follows reset is not counted.
- R8: After a `tx_ws` transition, `tx_sd` carries the MSB of the new word from the first falling bit-clock edge. The remaining bits follow, MSB first, one per falling edge. Once n bits are sent, `tx_sd` is low until the next word starts. `tx_sd` changes only in the system cycle after a detected falling edge.
- R9: `tx_left_in` and `tx_right_in` are latched together when a transition to low on `tx_ws` is detected. Changes to them at any later point in the frame do not affect the bits sent until the next left half-frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than `sck` |
| rst_n | input | 1 | Active-low reset |
| wl_sel | input | 2 | Word length select (0:16, 1:20, 2:24, 3:32) |
| sck | input | 1 | Serial bit clock from the master |
| rx_ws | input | 1 | Receive word select, low means left |
| rx_sd | input | 3 | Serial data, one bit per receive lane |
| tx_ws | input | 1 | Transmit word select, low means left |
| tx_left_in | input | 32 | Left word to transmit |
| tx_right_in | input | 32 | Right word to transmit |
| rx_left | output | 96 | Left words, 32 bits per lane |
| rx_right | output | 96 | Right words, 32 bits per lane |
| rx_valid | output | 1 | One-cycle strobe marking a complete stereo pair |
| rx_frame_err | output | 1 | One-cycle pulse when a short half-frame is dropped |
| tx_sd | output | 1 | Serial transmit data |

## Verification
The bench targets the one-bit offset after each word-select change. A design that captured on the first rising edge would shift every word by one place. A design that launched the transmit MSB too early would show it a whole bit period ahead.

Half-frames exactly n bits long put the LSB in the period where the word-select has already flipped. A design that closed the word on the transition itself, before capturing that bit, would lose the LSB or report false framing errors. Padding bits are driven high on receive, so a design that kept shifting past n would corrupt the right-justified words.

Short left and right half-frames check three things: the stored left word survives, no strobe appears for a dropped right word, and the error pulse fires. The transmit inputs are changed in the middle of a frame to catch a design that reads them live.

// File: rtl/i2s_port_pkg.sv
package i2s_port_pkg;

  typedef enum logic [1:0] {
    WLEN_16 = 2'd0,
    WLEN_20 = 2'd1,
    WLEN_24 = 2'd2,
    WLEN_32 = 2'd3
  } wlen_e;

  // Number of data bits carried per half-frame for a length select code
  function automatic int unsigned wlen_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WLEN_16: return 16;
      WLEN_20: return 20;
      WLEN_24: return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/i2s_sync.sv
module i2s_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_rise,
  input  logic          ws,
  input  logic [CW-1:0] nbits,
  output logic          cap,
  output logic          clr,
  output logic          store_l,
  output logic          store_r,
  output logic          pair_valid,
  output logic          frame_err
);
  logic          ws_prev_q;
  logic          chan_q;
  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic          err_q;

  // Bits gathered so far once the current edge's capture is counted
  function automatic logic [CW-1:0] gathered(input logic [CW-1:0] c, input logic take);
    return take ? CW'(c + 1'b1) : c;
  endfunction

  logic ws_flip;
  logic word_done;
  logic short_word;

  assign ws_flip    = bclk_rise && (ws != ws_prev_q);
  assign cap        = bclk_rise && active_q && (cnt_q < nbits);
  assign word_done  = cap && (gathered(cnt_q, 1'b1) == nbits);
  assign short_word = ws_flip && active_q && (gathered(cnt_q, cap) < nbits);
  assign clr        = ws_flip;
  assign store_l    = word_done && !chan_q;
  assign store_r    = word_done && chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      chan_q    <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      valid_q <= store_r;
      err_q   <= short_word;
      if (bclk_rise) ws_prev_q <= ws;
      if (ws_flip) begin
        cnt_q    <= '0;
        chan_q   <= ws;
        active_q <= 1'b1;
      end else if (cap) begin
        cnt_q <= gathered(cnt_q, 1'b1);
      end
    end
  end

  assign pair_valid = valid_q;
  assign frame_err  = err_q;

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= nbits);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          bit_in,
  input  logic          clr,
  input  logic          store_l,
  input  logic          store_r,
  output logic [DW-1:0] left_w,
  output logic [DW-1:0] right_w
);
  logic [DW-1:0] sh_q;
  logic [DW-1:0] shifted;

  assign shifted = {sh_q[DW-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      left_w  <= '0;
      right_w <= '0;
    end else begin
      if (store_l) left_w <= shifted;
      if (store_r) right_w <= shifted;
      if (clr) sh_q <= '0;
      else if (cap) sh_q <= shifted;
    end
  end
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_rise,
  input  logic          bclk_fall,
  input  logic          ws,
  input  logic [CW-1:0] nbits,
  input  logic [DW-1:0] word_l,
  input  logic [DW-1:0] word_r,
  output logic          sd
);
  localparam logic [CW-1:0] DWC = CW'(DW);

  // Place an n-bit word at the top of the shifter, zeros below
  function automatic logic [DW-1:0] msb_align(input logic [DW-1:0] w, input logic [CW-1:0] n);
    return w << (DWC - n);
  endfunction

  logic          ws_prev_q;
  logic          pend_q;
  logic          pch_q;
  logic [DW-1:0] hold_l_q;
  logic [DW-1:0] hold_r_q;
  logic [DW-1:0] sh_q;
  logic          sd_q;
  logic          tx_flip;
  logic [DW-1:0] start_word;

  assign tx_flip    = bclk_rise && (ws != ws_prev_q);
  assign start_word = msb_align(pch_q ? hold_r_q : hold_l_q, nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      pend_q    <= 1'b0;
      pch_q     <= 1'b0;
      hold_l_q  <= '0;
      hold_r_q  <= '0;
      sh_q      <= '0;
      sd_q      <= 1'b0;
    end else begin
      if (bclk_rise) ws_prev_q <= ws;
      if (tx_flip) begin
        pend_q <= 1'b1;
        pch_q  <= ws;
        if (!ws) begin
          hold_l_q <= word_l;
          hold_r_q <= word_r;
        end
      end else if (bclk_fall) begin
        if (pend_q) begin
          pend_q <= 1'b0;
          sd_q   <= start_word[DW-1];
          sh_q   <= start_word << 1;
        end else begin
          sd_q <= sh_q[DW-1];
          sh_q <= sh_q << 1;
        end
      end
    end
  end

  assign sd = sd_q;

  assert_tx_fall_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> $stable(sd_q));
endmodule

// File: rtl/i2s_audio_port.sv
module i2s_audio_port #(
  parameter int NLANE = 3,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DW + 1),
  localparam int SW   = NLANE + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         wl_sel,
  input  logic               sck,
  input  logic               rx_ws,
  input  logic [NLANE-1:0]   rx_sd,
  input  logic               tx_ws,
  input  logic [DW-1:0]      tx_left_in,
  input  logic [DW-1:0]      tx_right_in,
  output logic [NLANE*DW-1:0] rx_left,
  output logic [NLANE*DW-1:0] rx_right,
  output logic               rx_valid,
  output logic               rx_frame_err,
  output logic               tx_sd
);
  import i2s_port_pkg::*;

  logic [SW-1:0]    sync_out;
  logic [NLANE-1:0] sd_s;
  logic             sck_s, rxws_s, txws_s, sck_d;
  logic             bclk_rise, bclk_fall;
  logic [CW-1:0]    nbits;
  logic             cap, clr, store_l, store_r;

  i2s_sync #(.W(SW)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .din({tx_ws, rx_ws, sck, rx_sd}),
    .dout(sync_out)
  );
  assign {txws_s, rxws_s, sck_s, sd_s} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign bclk_rise = sck_s && !sck_d;
  assign bclk_fall = !sck_s && sck_d;

  always_comb begin
    nbits = CW'(wlen_bits(wl_sel));
    if (wlen_bits(wl_sel) > DW) nbits = CW'(DW);
  end

  i2s_rx_ctrl #(.DW(DW)) rx_ctrl_i (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .ws(rxws_s), .nbits(nbits),
    .cap(cap), .clr(clr), .store_l(store_l), .store_r(store_r),
    .pair_valid(rx_valid), .frame_err(rx_frame_err)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [DW-1:0] lw, rw;
    i2s_rx_lane #(.DW(DW)) lane_i (
      .clk(clk), .rst_n(rst_n), .cap(cap), .bit_in(sd_s[g]), .clr(clr),
      .store_l(store_l), .store_r(store_r), .left_w(lw), .right_w(rw)
    );
    assign rx_left[g*DW +: DW]  = lw;
    assign rx_right[g*DW +: DW] = rw;

    assert_right_just_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rw >> nbits) == '0));
  end

  i2s_tx #(.DW(DW)) tx_i (
    .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .ws(txws_s), .nbits(nbits), .word_l(tx_left_in), .word_r(tx_right_in), .sd(tx_sd)
  );
endmodule

// File: tb/i2s_audio_port_tb_top.sv
`timescale 1ns/1ps
module i2s_audio_port_tb_top;
  localparam int NL = 3;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, rx_ws = 1'b0, tx_ws = 1'b0;
  logic [1:0] wl_sel = 2'd3;
  logic [NL-1:0] rx_sd = '0;
  logic [DW-1:0] tx_left_in = '0, tx_right_in = '0;
  logic [NL*DW-1:0] rx_left, rx_right;
  logic rx_valid, rx_frame_err, tx_sd;

  always #2.5 clk = ~clk;

  i2s_audio_port dut_i (
    .clk(clk), .rst_n(rst_n), .wl_sel(wl_sel), .sck(sck), .rx_ws(rx_ws), .rx_sd(rx_sd),
    .tx_ws(tx_ws), .tx_left_in(tx_left_in), .tx_right_in(tx_right_in),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .tx_sd(tx_sd)
  );

  int n_total = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Behavioural model state
  int n_bits;
  logic [NL-1:0] carry_rx;
  logic carry_tx;
  logic [DW-1:0] last_left [NL];
  logic [DW-1:0] lat_l, lat_r;
  bit started;
  int prev_s;
  logic [2*NL*DW-1:0] exp_q[$];
  int exp_err, got_err;
  bit mon_en = 1'b0;

  function automatic logic [DW-1:0] keep_low(input logic [DW-1:0] w);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < n_bits; i++) r[i] = w[i];
    return r;
  endfunction

  function automatic logic rx_bit(input logic [DW-1:0] w, input int k, input bit pad);
    return (k < n_bits) ? w[n_bits-1-k] : pad;
  endfunction

  function automatic logic tx_bit(input logic [DW-1:0] w, input int k);
    return (k < n_bits) ? w[n_bits-1-k] : 1'b0;
  endfunction

  function automatic logic [NL*DW-1:0] lanes(input logic [DW-1:0] seed);
    logic [NL*DW-1:0] r;
    for (int l = 0; l < NL; l++) r[l*DW +: DW] = seed ^ (32'h0F1E_2D3C << l) ^ DW'(l * 7);
    return r;
  endfunction

  // Compare every clock: strobes against the predicted queue
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (rx_frame_err) got_err++;
      if (rx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected rx_valid", 1, 0);
        else begin
          logic [2*NL*DW-1:0] rec;
          rec = exp_q.pop_front();
          for (int l = 0; l < NL; l++) begin
            chk(rx_left[l*DW +: DW] === rec[l*DW +: DW],
                $sformatf("R2 R3 R5 R6 lane %0d left", l), rx_left[l*DW +: DW], rec[l*DW +: DW]);
            chk(rx_right[l*DW +: DW] === rec[(NL+l)*DW +: DW],
                $sformatf("R2 R3 R4 R5 lane %0d right", l), rx_right[l*DW +: DW], rec[(NL+l)*DW +: DW]);
          end
        end
      end
    end
  end

  task automatic bit_period(input logic ws, input logic [NL-1:0] d, input logic etx, input string tag);
    @(negedge clk);
    sck = 1'b0; rx_ws = ws; tx_ws = ws; rx_sd = d;
    repeat (4) @(negedge clk);
    chk(tx_sd === etx, {tag, " tx bit"}, {31'b0, tx_sd}, {31'b0, etx});
    sck = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic play_half(input logic ws, input int s, input logic [NL*DW-1:0] w, input bit pad, input string tag);
    logic [DW-1:0] txw;
    logic [NL-1:0] d;
    logic etx;
    if (started && prev_s < n_bits) exp_err++;
    if (!ws) begin lat_l = tx_left_in; lat_r = tx_right_in; end
    txw = ws ? lat_r : lat_l;
    if (s >= n_bits) begin
      if (!ws) begin
        for (int l = 0; l < NL; l++) last_left[l] = keep_low(w[l*DW +: DW]);
      end else begin
        logic [2*NL*DW-1:0] rec;
        for (int l = 0; l < NL; l++) begin
          rec[l*DW +: DW] = last_left[l];
          rec[(NL+l)*DW +: DW] = keep_low(w[l*DW +: DW]);
        end
        exp_q.push_back(rec);
      end
    end
    for (int j = 0; j < s; j++) begin
      if (j == 0) begin d = carry_rx; etx = carry_tx; end
      else begin
        for (int l = 0; l < NL; l++) d[l] = rx_bit(w[l*DW +: DW], j - 1, pad);
        etx = tx_bit(txw, j - 1);
      end
      bit_period(ws, d, etx, tag);
    end
    for (int l = 0; l < NL; l++) carry_rx[l] = rx_bit(w[l*DW +: DW], s - 1, pad);
    carry_tx = tx_bit(txw, s - 1);
    started = 1'b1;
    prev_s = s;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    mon_en = 1'b0;
    rst_n = 1'b0; sck = 1'b0; rx_ws = 1'b0; tx_ws = 1'b0; rx_sd = '0;
    tx_left_in = '0; tx_right_in = '0; wl_sel = sel;
    n_bits = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 20 : (sel == 2'd2) ? 24 : 32;
    carry_rx = '0; carry_tx = 1'b0; lat_l = '0; lat_r = '0;
    for (int l = 0; l < NL; l++) last_left[l] = '0;
    started = 1'b0; prev_s = 0; exp_q.delete(); exp_err = 0; got_err = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_section(input string tag);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R6 missing rx_valid"}, exp_q.size(), 0);
    chk(got_err == exp_err, {tag, " R7 frame error count"}, got_err, exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(2'd3);
    chk(rx_left === '0, "R1 rx_left after reset", rx_left[DW-1:0], 0);
    chk(rx_right === '0, "R1 rx_right after reset", rx_right[DW-1:0], 0);
    chk(rx_valid === 1'b0, "R1 rx_valid after reset", {31'b0, rx_valid}, 0);
    chk(rx_frame_err === 1'b0, "R1 rx_frame_err after reset", {31'b0, rx_frame_err}, 0);
    chk(tx_sd === 1'b0, "R1 tx_sd after reset", {31'b0, tx_sd}, 0);

    // 32-bit words, full slots
    play_half(1'b1, 32, '0, 1'b0, "R1 prime");
    tx_left_in = 32'hC0FF_EE11; tx_right_in = 32'h8000_0001;
    play_half(1'b0, 32, lanes(32'hA5A5_F00F), 1'b0, "R8 left32");
    play_half(1'b1, 32, lanes(32'h5A0F_3C96), 1'b0, "R8 right32");
    tx_left_in = 32'h1234_5678; tx_right_in = 32'hFEDC_BA98;
    play_half(1'b0, 32, lanes(32'hFFFF_0001), 1'b0, "R3 left32");
    play_half(1'b1, 32, lanes(32'h8000_7FFE), 1'b0, "R3 right32");
    play_half(1'b0, 4, '0, 1'b0, "R8 tail");
    end_section("wl32");

    // 16-bit words in 32-bit slots with high padding, mid-frame input change
    do_reset(2'd0);
    play_half(1'b1, 32, '0, 1'b1, "R4 prime");
    tx_left_in = 32'hDEAD_B00F; tx_right_in = 32'h0000_C3A5;
    play_half(1'b0, 32, lanes(32'h0BAD_F00D), 1'b1, "R4 pad left");
    tx_left_in = 32'h1111_1111; tx_right_in = 32'h2222_2222;
    play_half(1'b1, 32, lanes(32'h7777_9E37), 1'b1, "R9 mid-frame change");
    play_half(1'b0, 16, lanes(32'h0000_8001), 1'b0, "R9 relatch left16");
    play_half(1'b1, 16, lanes(32'h0000_4AF2), 1'b0, "R2 exact16");
    play_half(1'b0, 4, '0, 1'b0, "R8 tail");
    end_section("wl16");

    // 20-bit words with short half-frames
    do_reset(2'd1);
    play_half(1'b1, 24, '0, 1'b0, "R7 prime");
    tx_left_in = 32'h000A_BCDE; tx_right_in = 32'h0005_4321;
    play_half(1'b0, 24, lanes(32'h000F_1234), 1'b1, "R7 left24");
    play_half(1'b1, 12, lanes(32'h000E_EEEE), 1'b0, "R7 short right");
    play_half(1'b0, 24, lanes(32'h0003_3CC3), 1'b0, "R7 left after short");
    play_half(1'b1, 24, lanes(32'h0008_0808), 1'b1, "R7 recovery right");
    play_half(1'b0, 10, lanes(32'h000F_FFFF), 1'b1, "R7 short left");
    play_half(1'b1, 24, lanes(32'h0001_2345), 1'b0, "R7 keep old left");
    play_half(1'b0, 4, '0, 1'b0, "R8 tail");
    end_section("wl20");

    // 24-bit words
    do_reset(2'd2);
    play_half(1'b1, 24, '0, 1'b0, "R8 prime");
    tx_left_in = 32'h00A5_5A3C; tx_right_in = 32'hFF80_0001;
    play_half(1'b0, 24, lanes(32'h0091_8273), 1'b0, "R8 left24");
    play_half(1'b1, 24, lanes(32'h00C0_FFEE), 1'b0, "R8 right24");
    tx_left_in = 32'h0012_3456; tx_right_in = 32'h0065_4321;
    play_half(1'b0, 30, lanes(32'h0055_AA55), 1'b1, "R4 left30");
    play_half(1'b1, 30, lanes(32'h00AA_55AA), 1'b1, "R4 right30");
    play_half(1'b0, 4, '0, 1'b0, "R8 tail");
    end_section("wl24");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule